// File: doc/BRIEF.md
# Request/Grant Bus Handoff Controller

This block is the processor-side arbiter that lends the local bus to other masters over single-wire, active-low request/grant channels. Each channel carries a three-pulse exchange, and every pulse is low for exactly one clock. The borrowing master sends a request pulse. The controller answers with a grant pulse at a point where the bus may be given up, then floats the bus. The borrower later sends a release pulse, and the controller takes the bus back. Channel 0 wins when both channels ask in the same clock. A request that loses stays pending and is served after the exchange completes.

The controller watches the bus T-state that the bus unit reports. On an idle bus it grants in the next clock. During an active bus cycle it grants only after T4, and only when the request was seen no later than T2 and no blocking condition holds. The blocking conditions are an odd-address low byte, the first interrupt acknowledge, and a running locked instruction. A blocked request is tried again at every later T4.

The state machine has five states. LS_IDLE goes to LS_GRANT (transition *grant*) when an eligible request exists. LS_GRANT goes to LS_FLOAT (transition *float*) after one clock. LS_FLOAT goes to LS_RECLAIM (transition *release*) on the granted channel's release pulse. LS_RECLAIM goes to LS_COOL (transition *reclaim*) after one clock. LS_COOL goes back to LS_IDLE (transition *rearm*) after its single idle clock.

Top module: `bus_lend_ctrl`

## Requirements
- R1: While reset is held, and in the first clock after it, chan_oe is all zero, chan_drv_n is all ones, and bus_float, resume and resume_t4 are low.
- R2: Take a request (a low level on chan_in_n after a high one) sampled at edge k, with tstate idle (0) sampled at edge k+1 and no exchange in progress. The grant pulse is then driven on that channel alone in the clock after edge k+1, for exactly one clock.
- R3: chan_oe is high only on the granted channel, and only in the grant clock. chan_drv_n is low exactly where chan_oe is high and high everywhere else.
- R4: bus_float rises in the clock after the grant pulse. It stays high until the clock after the release pulse of the granted channel is sampled.
- R5: The clock after the release pulse is sampled, resume is high for one clock and bus_float is low. In that clock resume_t4 equals the cyc_pending value sampled with the release pulse.
- R6: In the two clocks after the resume clock, no grant pulse is driven on any channel. That gap holds even when a request is pending.
- R7: When both channels are eligible at the same edge, channel 0 is granted first. Channel 1 is granted once that exchange ends.
- R8: A request on the other channel while the bus is lent drives no grant and does not disturb bus_float. It stays pending and is granted in the third clock after the resume clock.
- R9: The tstate encoding is 0 idle, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4. During a bus cycle, a grant follows only a clock in which T4 is sampled. A request first sampled in T1 or T2 is granted in the clock after that T4.
- R10: When odd_lo_byte, first_inta or lock_active is high with T4, no grant follows. The request stays pending and is granted after the next T4 that has all three low.
- R11: A request first sampled in T3 or TW is not granted after that cycle's T4. It is granted after the next cycle's T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_in_n | input | NCH | Sampled level of each request/grant wire, active low |
| tstate | input | 3 | Bus T-state: 0 idle, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4 |
| cyc_pending | input | 1 | A bus cycle is waiting to run |
| odd_lo_byte | input | 1 | Current cycle is the low byte of a word at an odd address |
| first_inta | input | 1 | Current cycle is the first interrupt acknowledge |
| lock_active | input | 1 | A locked instruction is executing |
| chan_drv_n | output | NCH | Level driven onto each wire when enabled, active low |
| chan_oe | output | NCH | Drive enable for each wire, high only in the grant clock |
| bus_float | output | 1 | Bus drivers released to the borrowing master |
| resume | output | 1 | One-clock pulse as the bus is reclaimed |
| resume_t4 | output | 1 | With resume: continue at T4 (high) or at T1 (low) |

## Verification
The bench goes after the timing edges of the exchange. It checks a request at T2 against one at T3 or TW. A design that samples the window one phase late grants the T3 request too early. It also checks each blocker asserted alone at T4, where a missing term lets the bus go in the middle of a locked or split access. Two other targets are the mask on the granted channel's own grant and release clocks, and a competing request that arrives while the bus is lent. If the wrong channel is masked, or the pending request is not kept, the competing request is dropped or granted during the float. Finally, the bench checks the spacing between resume and the next grant. A controller with no idle clock grants one clock early.

// File: rtl/bus_lend_pkg.sv
package bus_lend_pkg;

    localparam int TS_W = 3;

    typedef enum logic [TS_W-1:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_T3   = 3'd3,
        TS_TW   = 3'd4,
        TS_T4   = 3'd5
    } tstate_e;

    typedef enum logic [2:0] {
        LS_IDLE    = 3'd0,
        LS_GRANT   = 3'd1,
        LS_FLOAT   = 3'd2,
        LS_RECLAIM = 3'd3,
        LS_COOL    = 3'd4
    } lend_state_e;

endpackage

// File: rtl/bl_chan_track.sv
// Per-channel request capture: falling-edge detect, pending flag and
// a "late" flag for requests first seen in T3/TW of the current cycle.
module bl_chan_track #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] chan_in_n,
    input  logic [NCH-1:0] mask,
    input  logic [NCH-1:0] clr,
    input  logic           late_win,
    input  logic           cycle_end,
    output logic [NCH-1:0] fall,
    output logic [NCH-1:0] pending,
    output logic [NCH-1:0] late
);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic prev_q;
        logic pend_q;
        logic late_q;
        logic set_req;

        assign fall[g]    = prev_q & ~chan_in_n[g];
        assign set_req    = fall[g] & ~mask[g];
        assign pending[g] = pend_q;
        assign late[g]    = late_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b1;
                pend_q <= 1'b0;
                late_q <= 1'b0;
            end else begin
                prev_q <= chan_in_n[g];
                if (clr[g]) begin
                    pend_q <= 1'b0;
                end else if (set_req) begin
                    pend_q <= 1'b1;
                end
                if (clr[g]) begin
                    late_q <= 1'b0;
                end else if (cycle_end) begin
                    late_q <= 1'b0;
                end else if (set_req && !pend_q && late_win) begin
                    late_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bl_release_gate.sv
// Decides per channel whether a pending request may be granted now.
module bl_release_gate
    import bus_lend_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0]  pending,
    input  logic [NCH-1:0]  late,
    input  logic [TS_W-1:0] tstate,
    input  logic            odd_lo_byte,
    input  logic            first_inta,
    input  logic            lock_active,
    output logic [NCH-1:0]  elig
);

    logic bus_idle;
    logic at_t4;
    logic blocked;

    assign bus_idle = (tstate == TS_IDLE);
    assign at_t4    = (tstate == TS_T4);
    assign blocked  = odd_lo_byte | first_inta | lock_active;

    for (genvar g = 0; g < NCH; g++) begin : g_gate
        assign elig[g] = pending[g] & (bus_idle | (at_t4 & ~late[g] & ~blocked));
    end

endmodule

// File: rtl/bl_prio_pick.sv
// Fixed priority: the lowest index wins.
module bl_prio_pick #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] pick,
    output logic           any
);

    logic [NCH-1:0] seen;

    for (genvar g = 0; g < NCH; g++) begin : g_pick
        if (g == 0) begin : g_first
            assign seen[g] = req[g];
            assign pick[g] = req[g];
        end else begin : g_rest
            assign seen[g] = seen[g-1] | req[g];
            assign pick[g] = req[g] & ~seen[g-1];
        end
    end

    assign any = seen[NCH-1];

endmodule

// File: rtl/bus_lend_ctrl.sv
// Request/grant bus handoff controller (processor side).
module bus_lend_ctrl
    import bus_lend_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  chan_in_n,
    input  logic [TS_W-1:0] tstate,
    input  logic            cyc_pending,
    input  logic            odd_lo_byte,
    input  logic            first_inta,
    input  logic            lock_active,
    output logic [NCH-1:0]  chan_drv_n,
    output logic [NCH-1:0]  chan_oe,
    output logic            bus_float,
    output logic            resume,
    output logic            resume_t4
);

    lend_state_e    st_q, st_d;
    logic [NCH-1:0] gsel_q, gsel_d;
    logic           rt4_q, rt4_d;

    logic [NCH-1:0] fall;
    logic [NCH-1:0] pending;
    logic [NCH-1:0] late;
    logic [NCH-1:0] elig;
    logic [NCH-1:0] pick;
    logic           any_elig;
    logic [NCH-1:0] mask;
    logic [NCH-1:0] clr;
    logic           rel_seen;
    logic           late_win;
    logic           cycle_end;

    assign late_win  = (tstate == TS_T3) || (tstate == TS_TW);
    assign cycle_end = (tstate == TS_T4);
    assign mask      = (st_q == LS_GRANT || st_q == LS_FLOAT) ? gsel_q : '0;
    assign clr       = (st_q == LS_IDLE && any_elig) ? pick : '0;
    assign rel_seen  = |(fall & gsel_q);

    bl_chan_track #(.NCH(NCH)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_in_n (chan_in_n),
        .mask      (mask),
        .clr       (clr),
        .late_win  (late_win),
        .cycle_end (cycle_end),
        .fall      (fall),
        .pending   (pending),
        .late      (late)
    );

    bl_release_gate #(.NCH(NCH)) u_gate (
        .pending     (pending),
        .late        (late),
        .tstate      (tstate),
        .odd_lo_byte (odd_lo_byte),
        .first_inta  (first_inta),
        .lock_active (lock_active),
        .elig        (elig)
    );

    bl_prio_pick #(.NCH(NCH)) u_pick (
        .req  (elig),
        .pick (pick),
        .any  (any_elig)
    );

    // next-state logic
    always_comb begin
        st_d   = st_q;
        gsel_d = gsel_q;
        rt4_d  = rt4_q;
        unique case (st_q)
            LS_IDLE: begin
                if (any_elig) begin
                    st_d   = LS_GRANT;
                    gsel_d = pick;
                end
            end
            LS_GRANT:   st_d = LS_FLOAT;
            LS_FLOAT: begin
                if (rel_seen) begin
                    st_d  = LS_RECLAIM;
                    rt4_d = cyc_pending;
                end
            end
            LS_RECLAIM: st_d = LS_COOL;
            LS_COOL:    st_d = LS_IDLE;
            default:    st_d = LS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= LS_IDLE;
            gsel_q <= '0;
            rt4_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            gsel_q <= gsel_d;
            rt4_q  <= rt4_d;
        end
    end

    // outputs
    always_comb begin
        chan_oe   = '0;
        bus_float = 1'b0;
        resume    = 1'b0;
        resume_t4 = 1'b0;
        unique case (st_q)
            LS_GRANT:   chan_oe = gsel_q;
            LS_FLOAT:   bus_float = 1'b1;
            LS_RECLAIM: begin
                resume    = 1'b1;
                resume_t4 = rt4_q;
            end
            default: ;
        endcase
        chan_drv_n = ~chan_oe;
    end

endmodule

// File: rtl/bus_lend_chk.sv
module bus_lend_chk
    import bus_lend_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [TS_W-1:0] tstate,
    input logic            odd_lo_byte,
    input logic            first_inta,
    input logic            lock_active,
    input logic [NCH-1:0]  chan_oe,
    input logic [NCH-1:0]  chan_drv_n,
    input logic            bus_float,
    input logic            resume
);

    assert_grant_single_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_oe != '0) |=> (chan_oe == '0));

    assert_oe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_oe) && ((chan_oe & chan_drv_n) == '0));

    assert_float_follows_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_oe != '0) |=> bus_float);

    assert_resume_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);

    assert_float_ends_with_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_float) |-> resume);

    assert_idle_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> (chan_oe == '0) ##1 (chan_oe == '0));

    assert_no_grant_while_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_float |-> (chan_oe == '0));

    assert_grant_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_oe != '0) |-> ($past(tstate) == TS_IDLE || $past(tstate) == TS_T4));

    assert_blockers_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((chan_oe != '0) && $past(tstate) == TS_T4)
            |-> !$past(odd_lo_byte || first_inta || lock_active));

endmodule

bind bus_lend_ctrl bus_lend_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tstate      (tstate),
    .odd_lo_byte (odd_lo_byte),
    .first_inta  (first_inta),
    .lock_active (lock_active),
    .chan_oe     (chan_oe),
    .chan_drv_n  (chan_drv_n),
    .bus_float   (bus_float),
    .resume      (resume)
);

// File: tb/tb_bus_lend_ctrl.sv
module tb_bus_lend_ctrl;

    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] chan_in_n = 2'b11;
    logic [2:0]     tstate = 3'd0;
    logic           cyc_pending = 1'b0;
    logic           odd_lo_byte = 1'b0;
    logic           first_inta = 1'b0;
    logic           lock_active = 1'b0;
    logic [NCH-1:0] chan_drv_n;
    logic [NCH-1:0] chan_oe;
    logic           bus_float;
    logic           resume;
    logic           resume_t4;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_lend_ctrl #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .chan_in_n(chan_in_n), .tstate(tstate),
        .cyc_pending(cyc_pending), .odd_lo_byte(odd_lo_byte),
        .first_inta(first_inta), .lock_active(lock_active),
        .chan_drv_n(chan_drv_n), .chan_oe(chan_oe), .bus_float(bus_float),
        .resume(resume), .resume_t4(resume_t4)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // ---------------- reference model from the requirements ----------------
    int       m_st = 0;      // 0 idle,1 grant,2 float,3 reclaim,4 cool
    bit [1:0] m_gsel = 0, m_pend = 0, m_late = 0, m_prev = 2'b11;
    bit       m_rt4 = 0;

    always @(posedge clk) begin : model
        bit [1:0] fall, mask, elig, pick, np, nl;
        bit t4, lw, blk, idl;
        #1;
        if (!rst_n) begin
            m_st = 0; m_gsel = 0; m_pend = 0; m_late = 0; m_prev = 2'b11; m_rt4 = 0;
        end else begin
            fall = m_prev & ~chan_in_n;
            mask = (m_st == 1 || m_st == 2) ? m_gsel : 2'b00;
            idl  = (tstate == 3'd0);
            t4   = (tstate == 3'd5);
            lw   = (tstate == 3'd3) || (tstate == 3'd4);
            blk  = odd_lo_byte | first_inta | lock_active;
            for (int i = 0; i < 2; i++)
                elig[i] = m_pend[i] && (idl || (t4 && !m_late[i] && !blk));
            pick = elig[0] ? 2'b01 : (elig[1] ? 2'b10 : 2'b00);
            np = m_pend; nl = m_late;
            for (int i = 0; i < 2; i++) begin
                if (m_st == 0 && pick[i]) begin
                    np[i] = 0; nl[i] = 0;
                end else begin
                    if (t4) nl[i] = 0;
                    else if (fall[i] && !mask[i] && !m_pend[i] && lw) nl[i] = 1;
                    if (fall[i] && !mask[i]) np[i] = 1;
                end
            end
            case (m_st)
                0: if (pick != 0) begin m_st = 1; m_gsel = pick; end
                1: m_st = 2;
                2: if ((fall & m_gsel) != 0) begin m_st = 3; m_rt4 = cyc_pending; end
                3: m_st = 4;
                default: m_st = 0;
            endcase
            m_pend = np; m_late = nl; m_prev = chan_in_n;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 chan_oe vs model", {6'd0, chan_oe}, {6'd0, (m_st == 1) ? m_gsel : 2'b00});
            chk("R3 chan_drv_n vs model", {6'd0, chan_drv_n}, {6'd0, ~((m_st == 1) ? m_gsel : 2'b00)});
            chk("R4 bus_float vs model", {7'd0, bus_float}, {7'd0, m_st == 2});
            chk("R5 resume vs model", {7'd0, resume}, {7'd0, m_st == 3});
            chk("R5 resume_t4 vs model", {7'd0, resume_t4}, {7'd0, (m_st == 3) && m_rt4});
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            wrap_up();
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input bit [1:0] who);
        chan_in_n = ~who;
        @(negedge clk);
        chan_in_n = 2'b11;
    endtask

    // release from FLOAT, then wait until the controller is back in idle
    task automatic release_ch(input bit [1:0] who, input string tag);
        pulse(who);
        chk({tag, " resume after release"}, {7'd0, resume}, 8'd1);
        tick(2);
    endtask

    // one bus cycle T1,T2,T3,[TW],T4; request on phase req_ph; blockers with T4
    task automatic mem_cycle(input int req_ph, input bit [1:0] rq, input bit tw,
                             input bit odd, input bit inta, input bit lck,
                             input string tag, output bit [1:0] oe_after);
        int n;
        logic [2:0] seq [5];
        n = tw ? 5 : 4;
        seq[0] = 3'd1; seq[1] = 3'd2; seq[2] = 3'd3;
        seq[3] = tw ? 3'd4 : 3'd5; seq[4] = 3'd5;
        for (int p = 0; p < n; p++) begin
            tstate      = seq[p];
            chan_in_n   = (p == req_ph) ? ~rq : 2'b11;
            odd_lo_byte = (p == n - 1) && odd;
            first_inta  = (p == n - 1) && inta;
            lock_active = (p == n - 1) && lck;
            @(negedge clk);
            if (p < n - 1) chk({tag, " no grant inside cycle"}, {6'd0, chan_oe}, 8'd0);
        end
        oe_after    = chan_oe;
        tstate      = 3'd0;
        chan_in_n   = 2'b11;
        odd_lo_byte = 0; first_inta = 0; lock_active = 0;
    endtask

    initial begin
        bit [1:0] oe;
        void'($urandom(32'd7321));
        // R1: reset state
        tick(3);
        chk("R1 chan_oe in reset", {6'd0, chan_oe}, 8'd0);
        chk("R1 chan_drv_n in reset", {6'd0, chan_drv_n}, 8'd3);
        chk("R1 bus_float/resume in reset", {6'd0, bus_float, resume}, 8'd0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 outputs after reset", {3'd0, chan_oe, bus_float, resume, resume_t4}, 8'd0);
        tick(1);

        // R2/R4/R5: idle grant on channel 0
        pulse(2'b01);
        chk("R2 no grant before decision", {6'd0, chan_oe}, 8'd0);
        tick(1);
        chk("R2 grant on ch0", {6'd0, chan_oe}, 8'd1);
        chk("R3 drive low on ch0", {6'd0, chan_drv_n}, 8'd2);
        tick(1);
        chk("R2 grant one clock wide", {6'd0, chan_oe}, 8'd0);
        chk("R4 float after grant", {7'd0, bus_float}, 8'd1);
        tick(2);
        chk("R4 float held", {7'd0, bus_float}, 8'd1);
        cyc_pending = 1'b1;
        pulse(2'b01);
        chk("R5 resume", {7'd0, resume}, 8'd1);
        chk("R5 resume_t4 with pending", {7'd0, resume_t4}, 8'd1);
        chk("R5 float dropped", {7'd0, bus_float}, 8'd0);
        cyc_pending = 1'b0;
        tick(1);
        chk("R5 resume one clock", {7'd0, resume}, 8'd0);
        tick(2);

        // R8/R6: other channel while lent, served after idle clock
        pulse(2'b01);
        tick(2);
        pulse(2'b10);
        chk("R8 other request ignored while lent", {5'd0, chan_oe, bus_float}, 8'd1);
        tick(1);
        chk("R8 still floating", {5'd0, chan_oe, bus_float}, 8'd1);
        pulse(2'b01);
        chk("R5 resume to T1", {6'd0, resume, resume_t4}, 8'd2);
        tick(1);
        chk("R6 idle clock 1", {6'd0, chan_oe}, 8'd0);
        tick(1);
        chk("R6 idle clock 2", {6'd0, chan_oe}, 8'd0);
        tick(1);
        chk("R8 pending ch1 granted", {6'd0, chan_oe}, 8'd2);
        tick(1);
        release_ch(2'b10, "R8");
        tick(1);

        // R7: simultaneous requests
        pulse(2'b11);
        tick(1);
        chk("R7 ch0 wins", {6'd0, chan_oe}, 8'd1);
        tick(1);
        pulse(2'b01);
        tick(3);
        chk("R7 ch1 served next", {6'd0, chan_oe}, 8'd2);
        tick(1);
        release_ch(2'b10, "R7");
        tick(1);

        // R9: request at T1 and at T2
        mem_cycle(0, 2'b01, 0, 0, 0, 0, "R9", oe);
        chk("R9 grant after T4 (req at T1)", {6'd0, oe}, 8'd1);
        tick(1);
        release_ch(2'b01, "R9");
        tick(1);
        mem_cycle(1, 2'b10, 1, 0, 0, 0, "R9", oe);
        chk("R9 grant after T4 (req at T2, wait state)", {6'd0, oe}, 8'd2);
        tick(1);
        release_ch(2'b10, "R9");
        tick(1);

        // R10: each blocker alone
        for (int b = 0; b < 3; b++) begin
            mem_cycle(0, 2'b01, 0, b == 0, b == 1, b == 2, "R10", oe);
            chk("R10 blocked at T4", {6'd0, oe}, 8'd0);
            mem_cycle(-1, 2'b00, 0, 0, 0, 0, "R10", oe);
            chk("R10 granted at next clear T4", {6'd0, oe}, 8'd1);
            tick(1);
            release_ch(2'b01, "R10");
            tick(1);
        end

        // R11: late request at T3 and at TW
        for (int w = 0; w < 2; w++) begin
            mem_cycle(w == 0 ? 2 : 3, 2'b01, w == 1, 0, 0, 0, "R11", oe);
            chk("R11 late request not granted", {6'd0, oe}, 8'd0);
            mem_cycle(-1, 2'b00, 0, 0, 0, 0, "R11", oe);
            chk("R11 granted at next T4", {6'd0, oe}, 8'd1);
            tick(1);
            release_ch(2'b01, "R11");
            tick(1);
        end

        // random phase, checked against the model every clock
        for (int c = 0; c < 4000; c++) begin
            tstate      = 3'($urandom_range(0, 5));
            cyc_pending = $urandom_range(0, 1) == 1;
            odd_lo_byte = $urandom_range(0, 5) == 0;
            first_inta  = $urandom_range(0, 5) == 0;
            lock_active = $urandom_range(0, 5) == 0;
            for (int i = 0; i < 2; i++) begin
                if (!chan_in_n[i]) chan_in_n[i] = 1'b1;
                else chan_in_n[i] = !($urandom_range(0, 4) == 0);
            end
            @(negedge clk);
        end
        chan_in_n = 2'b11;
        tick(4);
        wrap_up();
    end

endmodule